// File: doc/BRIEF.md
# Single-Outstanding Request/Acknowledge Monitor

This block watches a request/acknowledge handshake and enforces that at most one request is in flight at a time. A request is recognised only on a low-to-high transition of `req`. When no request is being tracked, that transition opens a tracked attempt and sets a busy lock. The attempt passes if `ack` is seen high on any of the cycles 1 to `MAX_WAIT` after the transition. A pass clears the lock.

A new request edge that arrives while the lock is set is reported at once as an extra-request error. One acknowledge therefore serves only the request that opened the attempt. If the tracked attempt sees no acknowledge inside its window, the monitor reports a failure and keeps the lock set. Every later request edge is then flagged until the `unlock` strobe or reset clears the lock.

The outcome outputs are single-cycle pulses. `locked` mirrors the busy lock as a level, so system logic or a test can see whether the monitor is holding.

Top module: `req_ack_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pass`, `fail`, `extra_req_err` and `locked` are all 0.
- R2: An attempt opens only on a rising edge of `req`: `req` sampled 1 at a clock edge after being sampled 0 at the edge before. Holding `req` high opens nothing further and raises no error.
- R3: When the open attempt sees `ack` high at the edge k cycles after the opening edge, with 1 <= k <= `MAX_WAIT` (default 10), `pass` is 1 for exactly the following cycle and `locked` drops to 0 in that same cycle.
- R4: `ack` high at the same edge as the opening `req` edge (delay 0) does not count toward a pass.
- R5: When no qualifying `ack` arrives by delay `MAX_WAIT`, `fail` is 1 for one cycle, `MAX_WAIT`+1 cycles after the opening edge, and `locked` stays 1. An `ack` after that produces no `pass`.
- R6: A `req` rising edge sampled while `locked` is 1 gives an `extra_req_err` pulse in the next cycle. It leaves the open attempt unchanged, so a later `ack` still passes only the first request.
- R7: `locked` becomes 1 in the cycle after an opening edge and returns to 0 only with a `pass` pulse or in the cycle after `unlock` was sampled high.
- R8: `unlock` sampled high clears the lock and any open attempt. No `pass` or `fail` follows from that attempt. A `req` rising edge sampled at the same edge as `unlock` is dropped: it opens nothing and raises no error.
- R9: `pass` and `fail` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request being monitored |
| ack | input | 1 | Acknowledge being monitored |
| unlock | input | 1 | Strobe that clears the lock and any open attempt |
| pass | output | 1 | One-cycle pulse: tracked attempt acknowledged in its window |
| fail | output | 1 | One-cycle pulse: tracked attempt timed out |
| extra_req_err | output | 1 | One-cycle pulse: request edge seen while locked |
| locked | output | 1 | Level: an attempt is open or a timeout is holding the lock |

## Verification
The bench acknowledges attempts at delay 1 and at delay `MAX_WAIT`, which pins both ends of the window. It also tries delay 0 alone and delay `MAX_WAIT`+1; each of these must end in a timeout, which separates an inclusive window from one that is off by one. A second request edge placed before the acknowledge shows that one acknowledge serves one request. A `req` held high shows that the monitor reacts to edges, not levels. The bench raises `unlock` during an open attempt and again at the same time as a request edge, to show that it cancels the outcome and drops a coincident edge, and it probes request edges after a timeout to confirm the lock is sticky.

// File: rtl/req_ack_monitor.sv
module req_ack_monitor #(
  parameter int MAX_WAIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  input  logic unlock,
  output logic pass,
  output logic fail,
  output logic extra_req_err,
  output logic locked
);
  localparam int CW = $clog2(MAX_WAIT + 1);

  logic          req_q;
  logic          busy;
  logic          tracking;
  logic [CW-1:0] cnt;

  wire rise   = req & ~req_q;
  wire hit    = tracking & ack;
  wire expire = tracking & ~ack & (cnt == CW'(MAX_WAIT));

  assign locked = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q         <= 1'b0;
      busy          <= 1'b0;
      tracking      <= 1'b0;
      cnt           <= '0;
      pass          <= 1'b0;
      fail          <= 1'b0;
      extra_req_err <= 1'b0;
    end else begin
      req_q         <= req;
      pass          <= 1'b0;
      fail          <= 1'b0;
      extra_req_err <= 1'b0;
      if (unlock) begin
        busy     <= 1'b0;
        tracking <= 1'b0;
        cnt      <= '0;
      end else begin
        if (hit) begin
          pass     <= 1'b1;
          busy     <= 1'b0;
          tracking <= 1'b0;
        end else if (expire) begin
          fail     <= 1'b1;
          tracking <= 1'b0;
        end else if (tracking) begin
          cnt <= cnt + 1'b1;
        end
        if (rise) begin
          if (busy) begin
            extra_req_err <= 1'b1;
          end else begin
            busy     <= 1'b1;
            tracking <= 1'b1;
            cnt      <= CW'(1);
          end
        end
      end
    end
  end

  assert_pass_fail_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_pass_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (!locked && $past(locked)));

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tracking |-> (cnt >= CW'(1) && cnt <= CW'(MAX_WAIT)));

  assert_fail_keeps_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> locked);

  assert_err_only_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    extra_req_err |-> $past(locked));

  assert_lock_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (pass || $past(unlock)));

  assert_unlock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unlock) |-> (!locked && !pass && !fail && !extra_req_err));

endmodule

// File: tb/sim_req_ack_monitor.sv
module sim_req_ack_monitor;
  localparam int PERIOD = 10;
  localparam int W      = 10;
  localparam int K_PASS = 0;
  localparam int K_FAIL = 1;
  localparam int K_ERR  = 2;

  typedef struct {
    int kind;
    int cyc;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ack = 1'b0, unlock = 1'b0;
  logic pass, fail, extra_req_err, locked;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;
  exp_t q[$];

  req_ack_monitor #(.MAX_WAIT(W)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .unlock(unlock),
    .pass(pass), .fail(fail), .extra_req_err(extra_req_err), .locked(locked)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string tag);
    exp_t e;
    int i;
    e.kind = kind; e.cyc = at; e.tag = tag;
    i = 0;
    while (i < q.size() && q[i].cyc <= at) i++;
    q.insert(i, e);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        chk(1'b0, {q[0].tag, " missed event"}, 0, q[0].kind);
        void'(q.pop_front());
      end
      if (pass || fail || extra_req_err) begin
        int kind;
        kind = pass ? K_PASS : (fail ? K_FAIL : K_ERR);
        if (q.size() == 0) begin
          chk(1'b0, "R8/R2 unexpected pulse", kind, -1);
        end else begin
          chk(q[0].kind == kind && q[0].cyc == cyc, q[0].tag, kind, q[0].kind);
          void'(q.pop_front());
        end
        if (pass && extra_req_err) begin
          chk(q.size() > 0 && q[0].kind == K_ERR && q[0].cyc == cyc, "R6 coincident err", 1, 1);
          if (q.size() > 0) void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s;
    tick(3);
    chk(!pass && !fail && !extra_req_err && !locked, "R1 in reset", locked, 0);
    rst_n = 1'b1;
    tick();
    chk(!pass && !fail && !extra_req_err && !locked, "R1 after reset", locked, 0);

    // R3: ack at delay 1
    s = cyc; req = 1'b1; expect_ev(K_PASS, s + 2, "R3 delay1 pass");
    tick(); req = 1'b0; ack = 1'b1;
    chk(locked == 1'b1, "R7 lock after open", locked, 1);
    tick(); ack = 1'b0;
    chk(locked == 1'b0, "R3 lock drops with pass", locked, 0);
    tick(2);

    // R3: ack at delay W
    s = cyc; req = 1'b1; expect_ev(K_PASS, s + 1 + W, "R3 delayW pass");
    tick(); req = 1'b0;
    tick(W - 1); ack = 1'b1;
    tick(); ack = 1'b0;
    chk(locked == 1'b0, "R3 unlocked after delayW", locked, 0);
    tick(2);

    // R6: second request before ack
    s = cyc; req = 1'b1; expect_ev(K_PASS, s + 4, "R6 first req pass");
    tick(); req = 1'b0;
    tick(); req = 1'b1; expect_ev(K_ERR, cyc + 1, "R6 extra req err");
    tick(); req = 1'b0; ack = 1'b1;
    tick(); ack = 1'b0;
    chk(locked == 1'b0, "R6 single ack frees lock", locked, 0);
    tick(3);
    chk(q.size() == 0, "R6 no second pass", q.size(), 0);

    // R2: req held high
    s = cyc; req = 1'b1; expect_ev(K_PASS, s + 3, "R2 held req pass");
    tick(2); ack = 1'b1;
    tick(); ack = 1'b0;
    tick(6);
    chk(locked == 1'b0, "R2 held req no reopen", locked, 0);
    req = 1'b0;
    tick(2);

    // R5: ack at delay W+1 -> fail, late ack ignored
    s = cyc; req = 1'b1; expect_ev(K_FAIL, s + 1 + W, "R5 timeout fail");
    tick(); req = 1'b0;
    tick(W); ack = 1'b1;
    tick(); ack = 1'b0;
    chk(locked == 1'b1, "R5 lock sticky after fail", locked, 1);
    tick(2);
    // R6: request while locked after timeout
    req = 1'b1; expect_ev(K_ERR, cyc + 1, "R6 err while timed out");
    tick(); req = 1'b0;
    tick(W + 2);
    chk(locked == 1'b1, "R5 still locked", locked, 1);
    // R8: unlock with coincident rise
    unlock = 1'b1; req = 1'b1;
    tick(); unlock = 1'b0;
    chk(locked == 1'b0, "R8 unlock clears", locked, 0);
    tick(W + 3);
    chk(locked == 1'b0, "R8 coincident rise dropped", locked, 1'b0);
    req = 1'b0;
    tick(2);

    // R4: ack only at delay 0 -> timeout
    s = cyc; req = 1'b1; ack = 1'b1; expect_ev(K_FAIL, s + 1 + W, "R4 delay0 ack ignored");
    tick(); req = 1'b0; ack = 1'b0;
    tick(W + 1);
    chk(locked == 1'b1, "R4 locked after delay0", locked, 1);
    unlock = 1'b1;
    tick(); unlock = 1'b0;
    tick();

    // R8: unlock during open attempt
    req = 1'b1;
    tick(); req = 1'b0;
    tick(2); unlock = 1'b1;
    tick(); unlock = 1'b0;
    chk(locked == 1'b0, "R8 unlock cancels attempt", locked, 0);
    tick(); ack = 1'b1;
    tick(); ack = 1'b0;
    tick(W + 2);
    chk(locked == 1'b0, "R8 no outcome after unlock", locked, 0);

    tick(3);
    chk(q.size() == 0, "R9 all expected events seen", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule